// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches one or more ports of `PORT_W` input pins and raises an interrupt request when a selected pin changes level. Each port forms a group. Every group has a per-pin select mask, an enable bit and a single sticky flag. Either edge on any selected pin of an enabled group sets that group's flag. The pins are first passed through a synchronizer of `SYNC_STAGES` flops. The current synchronized vector is then compared with its value one cycle earlier.

Software programs the block through a single-cycle write port. Address 0 holds the enable bits, one bit per group. Address 1 is the flag register: writing 1 to a bit clears that flag. Address 2+g holds the select mask of group g. The register contents are visible at all times on the read-back outputs. An interrupt controller consumes `irq_o` and pulses `ack_i` for a group when it takes that group's interrupt. The pulse clears that group's flag.

Top module: `pcint_group`

## Requirements
- R1: A low-to-high change on a pin whose mask bit is 1, in a group whose enable bit is 1, sets that group's flag.
- R2: A high-to-low change on such a pin also sets the group's flag.
- R3: A pin change has no effect on the flag unless both the pin's mask bit and the group's enable bit are 1 in the cycle the change is detected.
- R4: A write to address 1 with data bit g equal to 1 clears flag g. A data bit of 0 leaves its flag unchanged.
- R5: A one-cycle pulse on `ack_i[g]` clears flag g.
- R6: A change that happened while its pin was unmasked or its group disabled does not set the flag when the mask or enable is turned on later.
- R7: When a new qualifying change and a clear (write-one or acknowledge) reach a group in the same cycle, the flag ends up set.
- R8: `irq_o[g]` is 1 exactly when flag g and enable bit g are both 1. Clearing the enable keeps the flag but drops the request.
- R9: With a 2-stage synchronizer, a pin change present before rising edge N is visible on `flag_o` after edge N+2 and not after edge N+1.
- R10: Group g watches only `pins_i[g*PORT_W +: PORT_W]` through its own mask. Changes in one group never set another group's flag.
- R11: After reset, all masks, enables, flags and requests are 0.
- R12: Writing address 0 loads the enable bits from `wr_data[NUM_GROUPS-1:0]`. Writing address 2+g loads mask g from `wr_data[PORT_W-1:0]`. Both values read back on `enable_o` and `mask_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_GROUPS*PORT_W | Asynchronous pin levels, group g in slice g |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(NUM_GROUPS+2) | 0 enable, 1 flag (write-one-clear), 2+g mask of group g |
| wr_data | input | max(PORT_W, NUM_GROUPS) | Write data |
| ack_i | input | NUM_GROUPS | Interrupt taken; clears that group's flag |
| mask_o | output | NUM_GROUPS*PORT_W | Read-back of all select masks |
| enable_o | output | NUM_GROUPS | Read-back of group enables |
| flag_o | output | NUM_GROUPS | Group flags |
| irq_o | output | NUM_GROUPS | Interrupt request per group |

## Verification
Suppose the previous-value register or a synchronizer stage held a wrong bit. That would show up as a flag that sets with no matching pin activity, or that fails to set. It appears on `flag_o` two edges after the pin moves. A wrong clear priority shows in the single cycle where a change meets a write-one-clear or acknowledge: the flag reads 0 right after that edge instead of 1. A mask or enable bit stored wrongly is visible at once on the read-back outputs. It also shows as a flag that ignores, or wrongly follows, a selected toggle.

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int NUM_GROUPS  = 3,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W  = NUM_GROUPS * PORT_W,
  localparam int DATA_W = (PORT_W > NUM_GROUPS) ? PORT_W : NUM_GROUPS,
  localparam int ADDR_W = $clog2(NUM_GROUPS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIN_W-1:0]      pins_i,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_GROUPS-1:0] ack_i,
  output logic [PIN_W-1:0]      mask_o,
  output logic [NUM_GROUPS-1:0] enable_o,
  output logic [NUM_GROUPS-1:0] flag_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = '0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = ADDR_W'(1);

  logic [PIN_W-1:0]      sync_q [SYNC_STAGES];
  logic [PIN_W-1:0]      prev_q;
  logic [PORT_W-1:0]     mask_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] enable_q, flag_q, grp_hit, grp_clr;
  logic [PIN_W-1:0]      toggled;
  logic                  wr_flag;

  assign toggled = sync_q[SYNC_STAGES-1] ^ prev_q;
  assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pins_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = enable_q[g] & (|(toggled[g*PORT_W +: PORT_W] & mask_q[g]));
    assign grp_clr[g] = (wr_flag & wr_data[g]) | ack_i[g];
    assign mask_o[g*PORT_W +: PORT_W] = mask_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      flag_q   <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) mask_q[g] <= '0;
    end else begin
      flag_q <= (flag_q & ~grp_clr) | grp_hit;
      if (wr_en && (wr_addr == ADDR_ENABLE)) enable_q <= wr_data[NUM_GROUPS-1:0];
      for (int g = 0; g < NUM_GROUPS; g++)
        if (wr_en && (wr_addr == ADDR_W'(g + 2))) mask_q[g] <= wr_data[PORT_W-1:0];
    end
  end

  assign enable_o = enable_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & enable_q;
endmodule

// File: rtl/pcint_group_chk.sv
module pcint_group_chk #(
  parameter int NUM_GROUPS = 3,
  localparam int ADDR_W = $clog2(NUM_GROUPS + 2)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [NUM_GROUPS-1:0] wr_bits,
  input logic [NUM_GROUPS-1:0] ack_i,
  input logic [NUM_GROUPS-1:0] enable_o,
  input logic [NUM_GROUPS-1:0] flag_o,
  input logic [NUM_GROUPS-1:0] grp_hit
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_hit_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit[g] |=> flag_o[g]);
    assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit[g] |-> enable_o[g]);
    assert_rise_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[g]) |-> $past(grp_hit[g]));
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(1) && wr_bits[g] && !grp_hit[g]) |=> !flag_o[g]);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !grp_hit[g]) |=> !flag_o[g]);
  end
endmodule

bind pcint_group pcint_group_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bits(wr_data[NUM_GROUPS-1:0]), .ack_i(ack_i), .enable_o(enable_o),
  .flag_o(flag_o), .grp_hit(grp_hit)
);

// File: tb/pcint_group_test.sv
`timescale 1ns/1ps
module pcint_group_test;
  localparam int NG = 3;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*PW-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [PW-1:0] wr_data = '0;
  logic [NG-1:0] ack = '0;
  logic [NG*PW-1:0] mask_o;
  logic [NG-1:0] enable_o, flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pcint_group #(.NUM_GROUPS(NG), .PORT_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_i(ack), .mask_o(mask_o), .enable_o(enable_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  localparam logic [7:0] VMASK [8] = '{8'hFF, 8'hFF, 8'h0F, 8'h0F, 8'h80, 8'h80, 8'h00, 8'h42};
  localparam logic [7:0] VPIN  [8] = '{8'h01, 8'h00, 8'h10, 8'h18, 8'h19, 8'h99, 8'h66, 8'h64};
  localparam logic       VEXP  [8] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R11 mask", mask_o, 0);
    check("R11 enable", enable_o, 0);
    check("R11 flag", flag_o, 0);
    check("R11 irq", irq_o, 0);

    wr(3'd0, 8'h01);
    check("R12 enable readback", enable_o, 3'b001);
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, VMASK[i]);
      pins[7:0] = VPIN[i];
      tick(3);
      check("R1 R2 R3 vector flag", flag_o[0], VEXP[i]);
      check("R8 vector irq", irq_o[0], VEXP[i]);
      wr(3'd1, 8'h01);
    end

    // R9 latency, R4 write of zero
    wr(3'd2, 8'hFF);
    pins[0] = ~pins[0];
    tick(2);
    check("R9 not yet after edge N+1", flag_o[0], 1'b0);
    tick(1);
    check("R9 set after edge N+2", flag_o[0], 1'b1);
    wr(3'd1, 8'h00);
    check("R4 zero bit keeps flag", flag_o[0], 1'b1);
    wr(3'd1, 8'h01);
    check("R4 one bit clears flag", flag_o[0], 1'b0);

    // R5 acknowledge
    pins[1] = ~pins[1];
    tick(3);
    check("R5 flag before ack", flag_o[0], 1'b1);
    ack = 3'b001; tick(1); ack = '0;
    check("R5 ack clears", flag_o[0], 1'b0);

    // R7 collisions
    pins[2] = ~pins[2];
    tick(3);
    pins[3] = ~pins[3];
    tick(2);
    wr(3'd1, 8'h01);
    check("R7 change beats write-one-clear", flag_o[0], 1'b1);
    pins[4] = ~pins[4];
    tick(2);
    ack = 3'b001; tick(1); ack = '0;
    check("R7 change beats ack", flag_o[0], 1'b1);
    wr(3'd1, 8'h01);
    check("R7 flag clears afterwards", flag_o[0], 1'b0);

    // R3/R6 disabled group, then enable
    wr(3'd0, 8'h00);
    pins[5] = ~pins[5];
    tick(4);
    check("R3 disabled group ignores change", flag_o[0], 1'b0);
    wr(3'd0, 8'h01);
    tick(3);
    check("R6 no late set after enable", flag_o[0], 1'b0);
    wr(3'd2, 8'h00);
    pins[6] = ~pins[6];
    tick(4);
    wr(3'd2, 8'hFF);
    tick(3);
    check("R6 no late set after unmask", flag_o[0], 1'b0);

    // R8 gating by enable
    pins[7] = ~pins[7];
    tick(3);
    wr(3'd0, 8'h00);
    check("R8 flag kept when disabled", flag_o[0], 1'b1);
    check("R8 irq dropped when disabled", irq_o[0], 1'b0);
    wr(3'd0, 8'h01);
    check("R8 irq back when re-enabled", irq_o[0], 1'b1);
    wr(3'd1, 8'h07);

    // R10 group isolation, R12 mask readback
    wr(3'd0, 8'h03);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'hA5);
    check("R12 enable readback", enable_o, 3'b011);
    check("R12 mask readback", mask_o, 24'hA501FF);
    pins[8] = 1'b1;
    tick(3);
    check("R10 only group 1 flagged", flag_o, 3'b010);
    pins[9] = 1'b1;
    pins[16] = 1'b1;
    tick(3);
    check("R10 unmasked and disabled groups", flag_o, 3'b010);
    check("R10 irq per group", irq_o, 3'b010);

    summary();
    $finish;
  end
endmodule